// File: doc/BRIEF.md
# Spike Event Timestamping Capture Unit

This block watches up to eight asynchronous one-bit spike lines coming from threshold comparators. Each line passes through a synchroniser, and only a low-to-high change counts as an event. The event is tagged with the value of a free-running time counter that advances once per microsecond, which is one tick every 64 clocks of the 64 MHz system clock.

Every event produces a one-cycle strobe carrying the channel index, for use by downstream connectivity logic. The event is also stored as a 32-bit record in a FIFO. A host drains the FIFO through a small register interface. When several lines rise in the same cycle, every one of them is captured with the same time value and delivered one per cycle, lowest channel first. A level interrupt lets a host that is waiting on an empty buffer wake up as soon as data is present. The time counter wraps modulo 2^29.

Top module: `spike_capture`

## Requirements
- R1: After reset the status word reads 0, the control word reads 0, `irq` is low and `evtValid` is low.
- R2: A 0-to-1 change on a spike input, held for at least three clocks, yields exactly one event. A line that stays high, or that falls, yields none. For a lone spike, `evtValid` is high, with `evtId` equal to the channel, during the third clock cycle after the input rises.
- R3: The time counter is 0 at reset release and increments once every TICK_DIV clocks (default 64). A record carries the counter value that stands just after the second rising clock edge following the input's rise.
- R4: Channels that rise in the same cycle share one time value. They are delivered on consecutive cycles in ascending channel order, one strobe per cycle.
- R5: A read of address 0 returns the oldest record and removes it. Bits [2:0] of the record hold the channel and bits [31:3] hold the time. A read of address 0 while the FIFO is empty returns 0 and removes nothing.
- R6: The FIFO holds FIFO_DEPTH records (default 16). An event that arrives while it is full is not stored and sets the overflow flag. The strobe is still emitted.
- R7: The overflow flag (status bit 2) stays set until a write to address 1 with bit 2 set. A write to address 1 with bit 2 clear leaves it set.
- R8: `irq` is high exactly while the FIFO is non-empty and control bit 0 (written at address 2) is 1.
- R9: The status word at address 1 carries the non-empty flag in bit 0, the full flag in bit 1 and the record count in bits [12:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spikeIn | input | 8 | Asynchronous spike lines, one per channel |
| evtValid | output | 1 | One-cycle event strobe |
| evtId | output | 3 | Channel index of the strobed event |
| hostAddr | input | 2 | Register select: 0 data, 1 status, 2 control |
| hostWr | input | 1 | Register write enable |
| hostRd | input | 1 | Register read enable (pops at address 0) |
| hostWdata | input | 32 | Write data |
| hostRdata | output | 32 | Read data for the selected address, combinational |
| irq | output | 1 | Level interrupt, data available |

## Verification
The assertions assume that each spike line is a clean level that stays high or low for several clocks. They also assume that a channel does not rise again while its previous event is still waiting to be delivered. The overflow and interrupt checks further assume that the host touches only the three defined addresses. The stimulus holds every pulse for at least four clocks and leaves at least four more idle clocks before the next one. It fires channels either together in one cycle or well apart. Host accesses are driven on the falling edge, one register per access.

// File: rtl/spkcap_pkg.sv
package spkcap_pkg;
  localparam int SPK_CH   = 8;
  localparam int SPK_ID_W = $clog2(SPK_CH);
  localparam int WORD_W   = 32;
  localparam int SPK_TS_W = WORD_W - SPK_ID_W;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  // strobe bundle from control to datapath
  typedef struct packed {
    logic                push;
    logic [SPK_ID_W-1:0] id;
    logic [SPK_TS_W-1:0] stamp;
  } spk_evt_t;
endpackage

// File: rtl/spkcap_ctrl.sv
module spkcap_ctrl
  import spkcap_pkg::*;
#(
  parameter int TICK_DIV = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SPK_CH-1:0] spikeIn,
  output spk_evt_t          evt
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0]    preCnt;
  logic [SPK_TS_W-1:0] tsNow;
  logic [SPK_CH-1:0]   riseVec;
  logic [SPK_CH-1:0]   pending;
  logic [SPK_CH-1:0]   grantVec;
  logic [SPK_ID_W-1:0] grantId;
  logic [SPK_CH-1:0][SPK_TS_W-1:0] stampArr;

  // microsecond tick and free-running time counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      tsNow  <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt <= '0;
      tsNow  <= tsNow + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // per-channel synchroniser, edge detect and stamp latch
  for (genvar c = 0; c < SPK_CH; c++) begin : g_chan
    logic [2:0] syncSh;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncSh <= '0;
      else       syncSh <= {syncSh[1:0], spikeIn[c]};
    end
    assign riseVec[c] = syncSh[1] & ~syncSh[2];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           stampArr[c] <= '0;
      else if (riseVec[c]) stampArr[c] <= tsNow;
    end
  end

  // lowest pending channel wins
  assign grantVec = pending & (~pending + 1'b1);

  always_comb begin
    grantId = '0;
    for (int c = SPK_CH - 1; c >= 0; c--) begin
      if (pending[c]) grantId = SPK_ID_W'(c);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= '0;
    else       pending <= (pending & ~grantVec) | riseVec;
  end

  assign evt.push  = |pending;
  assign evt.id    = grantId;
  assign evt.stamp = stampArr[grantId];
endmodule

// File: rtl/spkcap_data.sv
module spkcap_data
  import spkcap_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  spk_evt_t          evt,
  input  logic [1:0]        hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic              irq
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FIFO_DEPTH);

  logic [WORD_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fifoCnt;
  logic              ovfFlag;
  logic              irqEn;
  logic              notEmpty, isFull, doPush, doPop, ovfClr;
  logic [WORD_W-1:0] statWord;

  assign notEmpty = (fifoCnt != '0);
  assign isFull   = (fifoCnt == CNT_FULL);
  assign doPush   = evt.push && !isFull;
  assign doPop    = hostRd && (hostAddr == ADDR_DATA) && notEmpty;
  assign ovfClr   = hostWr && (hostAddr == ADDR_STAT) && hostWdata[2];

  always_ff @(posedge clk) begin
    if (doPush) fifoMem[wrPtr] <= {evt.stamp, evt.id};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fifoCnt <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fifoCnt <= fifoCnt + 1'b1;
        2'b01:   fifoCnt <= fifoCnt - 1'b1;
        default: fifoCnt <= fifoCnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        ovfFlag <= 1'b0;
    else if (evt.push && isFull)      ovfFlag <= 1'b1;
    else if (ovfClr)                  ovfFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  irqEn <= 1'b0;
    else if (hostWr && hostAddr == ADDR_CTRL)   irqEn <= hostWdata[0];
  end

  always_comb begin
    statWord = '0;
    statWord[0] = notEmpty;
    statWord[1] = isFull;
    statWord[2] = ovfFlag;
    statWord[8 +: CNT_W] = fifoCnt;
  end

  always_comb begin
    case (hostAddr)
      ADDR_DATA: hostRdata = notEmpty ? fifoMem[rdPtr] : '0;
      ADDR_STAT: hostRdata = statWord;
      ADDR_CTRL: hostRdata = {{(WORD_W-1){1'b0}}, irqEn};
      default:   hostRdata = '0;
    endcase
  end

  assign irq = notEmpty && irqEn;
endmodule

// File: rtl/spike_capture.sv
module spike_capture
  import spkcap_pkg::*;
#(
  parameter int TICK_DIV   = 64,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SPK_CH-1:0] spikeIn,
  output logic              evtValid,
  output logic [SPK_ID_W-1:0] evtId,
  input  logic [1:0]        hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic              irq
);
  spk_evt_t evtBus;

  spkcap_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .spikeIn (spikeIn),
    .evt     (evtBus)
  );

  spkcap_data #(.FIFO_DEPTH(FIFO_DEPTH)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evtBus),
    .hostAddr  (hostAddr),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .irq       (irq)
  );

  assign evtValid = evtBus.push;
  assign evtId    = evtBus.id;
endmodule

// File: rtl/spike_capture_chk.sv
module spike_capture_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             evtValid,
  input logic [1:0]       hostAddr,
  input logic             hostWr,
  input logic             hostRd,
  input logic [31:0]      hostWdata,
  input logic             irq,
  input logic [CNT_W-1:0] fifoCnt,
  input logic             ovfFlag
);
  // R7: overflow stays until an explicit clear write
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !(hostWr && hostAddr == 2'd1 && hostWdata[2]) |=> ovfFlag);

  // R6: a full FIFO stays full when an event arrives and nothing is popped
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCnt == CNT_W'(DEPTH)) && evtValid && !(hostRd && hostAddr == 2'd0)
    |=> fifoCnt == CNT_W'(DEPTH));

  // R8: interrupt only drops after a host access
  a_r8_irq_drop_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> ($past(hostRd) || $past(hostWr)));

  // R5: occupancy moves by at most one record per cycle
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCnt == $past(fifoCnt)) || (fifoCnt == $past(fifoCnt) + 1'b1)
    || (fifoCnt == $past(fifoCnt) - 1'b1));

  // R6: occupancy never exceeds the depth
  a_r6_no_overfill: assert property (@(posedge clk) disable iff (!rstN)
    fifoCnt <= CNT_W'(DEPTH));
endmodule

bind spike_capture spike_capture_chk #(
  .DEPTH (FIFO_DEPTH),
  .CNT_W ($clog2(FIFO_DEPTH + 1))
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtValid  (evtValid),
  .hostAddr  (hostAddr),
  .hostWr    (hostWr),
  .hostRd    (hostRd),
  .hostWdata (hostWdata),
  .irq       (irq),
  .fifoCnt   (u_data.fifoCnt),
  .ovfFlag   (u_data.ovfFlag)
);

// File: tb/spike_capture_tb.sv
module spike_capture_tb;
  localparam int TICK = 64;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  spikeIn = '0;
  logic        evtValid;
  logic [2:0]  evtId;
  logic [1:0]  hostAddr = '0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int edgeCnt = 0;
  int expCnt = 0;
  logic [2:0]  strobeQ[$];
  logic [31:0] recQ[$];

  always #10 clk = ~clk;

  spike_capture #(.TICK_DIV(TICK), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .spikeIn(spikeIn), .evtValid(evtValid), .evtId(evtId),
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .irq(irq));

  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: strobes must match the queue in order (R2, R4, R6)
  always @(negedge clk) begin
    if (rstN && evtValid) begin
      if (strobeQ.size() == 0) check("R2 unexpected strobe", {29'd0, evtId}, 32'hffff_ffff);
      else check("R4 strobe id", {29'd0, evtId}, {29'd0, strobeQ.pop_front()});
    end
  end

  // driver: fire the channels in mask together, predict their outputs
  task automatic fire(input logic [7:0] mask, input int hold);
    logic [28:0] stamp;
    @(negedge clk);
    stamp = 29'((edgeCnt + 2) / TICK);
    for (int c = 0; c < 8; c++) begin
      if (mask[c]) begin
        strobeQ.push_back(3'(c));
        if (expCnt < DEPTH) begin
          recQ.push_back({stamp, 3'(c)});
          expCnt++;
        end
      end
    end
    spikeIn = spikeIn | mask;
    repeat (hold) @(negedge clk);
    spikeIn = spikeIn & ~mask;
    repeat (12) @(negedge clk);
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic drain(input string tag);
    logic [31:0] d;
    while (recQ.size() > 0) begin
      hostRead(2'd0, d);
      check(tag, d, recQ.pop_front());
      expCnt--;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    #1;
    check("R1 evtValid", {31'd0, evtValid}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    hostRead(2'd1, d); check("R1 status", d, 0);
    hostRead(2'd2, d); check("R1 control", d, 0);

    // R5 empty read returns zero, no pop
    hostRead(2'd0, d); check("R5 empty read", d, 0);
    hostRead(2'd1, d); check("R5 empty status", d, 0);

    // R2/R3 lone spikes on several channels at different times
    fire(8'h01, 4);
    repeat (70) @(negedge clk);
    fire(8'h20, 4);
    repeat (130) @(negedge clk);
    fire(8'h80, 4);
    hostRead(2'd1, d); check("R9 status three", d, 32'h0000_0301);
    drain("R3 lone record");

    // R2 strobe timing: third cycle after rise
    @(negedge clk);
    spikeIn = 8'h08;
    strobeQ.push_back(3'd3);
    recQ.push_back({29'((edgeCnt + 2) / TICK), 3'd3}); expCnt++;
    @(negedge clk); check("R2 no strobe c1", {31'd0, evtValid}, 0);
    @(negedge clk); check("R2 no strobe c2", {31'd0, evtValid}, 0);
    @(negedge clk); check("R2 strobe c3", {31'd0, evtValid}, 1);
    repeat (2) @(negedge clk);
    spikeIn = 8'h00;
    repeat (10) @(negedge clk);
    drain("R2 timed record");

    // R2 long hold gives a single event, fall gives none
    fire(8'h40, 150);
    hostRead(2'd1, d); check("R2 single count", d, 32'h0000_0101);
    drain("R2 hold record");

    // R4 simultaneous channels, ascending order with shared time
    repeat (33) @(negedge clk);
    fire(8'hA6, 4);
    fire(8'hFF, 5);
    hostRead(2'd1, d); check("R9 status twelve", d, 32'h0000_0C01);
    drain("R4 group record");

    // R8 interrupt
    hostWrite(2'd2, 32'h1);
    hostRead(2'd2, d); check("R8 control", d, 1);
    #1 check("R8 irq idle", {31'd0, irq}, 0);
    fire(8'h04, 4);
    check("R8 irq up", {31'd0, irq}, 1);
    hostWrite(2'd2, 32'h0);
    #1 check("R8 irq masked", {31'd0, irq}, 0);
    hostWrite(2'd2, 32'h1);
    #1 check("R8 irq back", {31'd0, irq}, 1);
    drain("R8 record");
    #1 check("R8 irq empty", {31'd0, irq}, 0);
    hostWrite(2'd2, 32'h0);

    // R6 fill and overflow
    for (int i = 0; i < DEPTH; i++) fire(8'(1 << (i % 8)), 4);
    hostRead(2'd1, d); check("R6 full status", d, 32'h0000_1003);
    fire(8'h10, 4);
    fire(8'h02, 4);
    hostRead(2'd1, d); check("R6 overflow status", d, 32'h0000_1007);
    // R7 clear semantics
    hostWrite(2'd1, 32'h0);
    hostRead(2'd1, d); check("R7 keep", d, 32'h0000_1007);
    hostWrite(2'd1, 32'h4);
    hostRead(2'd1, d); check("R7 cleared", d, 32'h0000_1003);
    drain("R6 kept record");
    hostRead(2'd1, d); check("R6 empty after", d, 0);
    check("R4 strobes consumed", strobeQ.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule